// File: doc/BRIEF.md
# Cluster Performance and Config-Read Request Engine

This block accepts requests over a simple register bus and runs one timed operation at a time. A write to either cluster's performance register asks for a new performance level for that cluster. A write of a command word with its start bit set asks for one word from a small internal clock-configuration table. Each request runs for a fixed number of clock cycles, set by a parameter. When the operation ends, the block posts a completion or an error flag in the status nibble that belongs to the request type. It also raises a level-high interrupt, which stays high until software reads the status register.

Software programs a level or issues a command, then waits for the interrupt. It reads the status register, which also acknowledges the interrupt. It then reads back either the performance register or the config-data register. While an operation is running, the block drops any new request without leaving a trace. The long settling time of real hardware becomes a cycle count, which simulation can shorten.

Top module: `dvfs_req_engine`

## Requirements
- R1: After reset the status word is 0, the interrupt is low, both performance registers read 0 and the config-data register reads 0.
- R2: Offset 0x00 is the cluster 0 performance register and offset 0x08 is the cluster 1 performance register. A write to either starts a request of type 0 or type 1 respectively. On success the status bit 4*type is set, which is bit 0 or bit 4.
- R3: A request's status appears exactly OP_CYCLES clock cycles after the bus cycle that accepted it, and no earlier.
- R4: A performance index of 8 or more completes with the error bit set, bit 4*type+1 (bit 1 or bit 5), and with the complete bit clear.
- R5: A performance register reads back the current level. The level changes only when a performance request for that cluster completes without error.
- R6: Offset 0x10 is the command register. A write there with bit 31 set, function field [23:20] equal to 6 and word offset [11:0] below 16 starts a type 2 read that sets status bit 8. The word readable at offset 0x74 then becomes {8'hC5, offset[7:0], 16'(offset*3+1)}.
- R7: A config read with a function other than 6, or with a word offset of 16 or more, sets status bit 9, leaves bit 8 clear and leaves the word at 0x74 unchanged.
- R8: A command-register write with bit 31 clear starts nothing and changes no status bit.
- R9: A request that arrives while an operation is running is ignored. It changes no status bit and no register.
- R10: A read of the status register at offset 0x18 returns the status bits and clears all of them, which lowers the interrupt.
- R11: The interrupt output is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle busSel is high |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest case to reach from the ports is a second request that lands while the first is still counting. The bench issues a performance write and, on the very next bus cycle, writes the other cluster's register. It then also sends a started command word inside the same window. Afterwards it checks that only the first request's status bit appears and that the other cluster's level and the config word are untouched. The timing boundary is pinned by watching the interrupt pin on the cycles on either side of the OP_CYCLES mark, without reading the status register, because that read would clear it.

// File: rtl/dvfs_req_pkg.sv
package dvfs_req_pkg;

  typedef enum logic [1:0] {
    KIND_PERF0 = 2'd0,
    KIND_PERF1 = 2'd1,
    KIND_CFG   = 2'd2
  } reqKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic        finish;
    reqKind_t    kind;
    logic [31:0] arg;
  } opStrobe_t;

  localparam int NUM_KINDS   = 3;
  localparam int NUM_CLUSTER = 2;

  localparam logic [7:0] OFS_PERF0  = 8'h00;
  localparam logic [7:0] OFS_PERF1  = 8'h08;
  localparam logic [7:0] OFS_CMD    = 8'h10;
  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_RDATA  = 8'h74;

  localparam int CMD_START_BIT = 31;

endpackage

// File: rtl/dvfs_req_ctrl.sv
module dvfs_req_ctrl
  import dvfs_req_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OP_CYCLES = 150000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output opStrobe_t         opStrobe,
  output logic              busy
);

  localparam int CNT_W = $clog2(OP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  reqKind_t         kindQ;
  logic [31:0]      argQ;
  logic             startReq;
  reqKind_t         kindNext;

  always_comb begin
    startReq = 1'b0;
    kindNext = KIND_PERF0;
    if (busSel && busWrite && !busy) begin
      if (busAddr == ADDR_W'(OFS_PERF0)) begin
        startReq = 1'b1;
        kindNext = KIND_PERF0;
      end else if (busAddr == ADDR_W'(OFS_PERF1)) begin
        startReq = 1'b1;
        kindNext = KIND_PERF1;
      end else if (busAddr == ADDR_W'(OFS_CMD) && busWdata[CMD_START_BIT]) begin
        startReq = 1'b1;
        kindNext = KIND_CFG;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      kindQ <= KIND_PERF0;
      argQ  <= '0;
    end else if (startReq) begin
      busy  <= 1'b1;
      cnt   <= CNT_LAST;
      kindQ <= kindNext;
      argQ  <= busWdata;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign opStrobe.finish = busy && (cnt == '0);
  assign opStrobe.kind   = kindQ;
  assign opStrobe.arg    = argQ;

  AST_FINISH_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe.finish |=> !busy);  // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opStrobe.finish) |=> busy);  // R3
  AST_REQ_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opStrobe.finish) |=> ($stable(kindQ) && $stable(argQ)));  // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LAST);  // R3

endmodule

// File: rtl/dvfs_req_datapath.sv
module dvfs_req_datapath
  import dvfs_req_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_LEVELS = 8,
  parameter int CFG_WORDS  = 16,
  parameter int CFG_FUNC   = 6,
  parameter int OFF_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  opStrobe_t         opStrobe,
  output logic [31:0]       busRdata,
  output logic              irq
);

  localparam int LVL_W  = $clog2(NUM_LEVELS);
  localparam int STAT_W = 4 * NUM_KINDS;

  logic [LVL_W-1:0]  perfLvl [NUM_CLUSTER];
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] statusSet;
  logic [31:0]       cfgData;
  logic              isPerf, perfOk, cfgOk, okNow, rdStatus;
  logic [OFF_W-1:0]  wordOff;
  logic [31:0]       cfgWord;

  assign isPerf  = (opStrobe.kind != KIND_CFG);
  assign perfOk  = (opStrobe.arg < 32'(NUM_LEVELS));
  assign wordOff = opStrobe.arg[OFF_W-1:0];
  assign cfgOk   = (opStrobe.arg[23:20] == 4'(CFG_FUNC)) && (wordOff < OFF_W'(CFG_WORDS));
  assign okNow   = isPerf ? perfOk : cfgOk;
  assign cfgWord = {8'hC5, 8'(wordOff), 16'(wordOff) * 16'd3 + 16'd1};

  always_comb begin
    statusSet = '0;
    if (opStrobe.finish)
      statusSet[4 * int'(opStrobe.kind) + (okNow ? 0 : 1)] = 1'b1;
  end

  assign rdStatus = busSel && !busWrite && (busAddr == ADDR_W'(OFS_STATUS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         status <= '0;
    else if (rdStatus) status <= statusSet;
    else               status <= status | statusSet;
  end

  for (genvar c = 0; c < NUM_CLUSTER; c++) begin : g_cluster
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        perfLvl[c] <= '0;
      else if (opStrobe.finish && isPerf && perfOk && (int'(opStrobe.kind) == c))
        perfLvl[c] <= opStrobe.arg[LVL_W-1:0];
    end

    AST_LEVEL_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rstN)
      !(opStrobe.finish && perfOk && (int'(opStrobe.kind) == c)) |=> $stable(perfLvl[c]));  // R5
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cfgData <= '0;
    else if (opStrobe.finish && !isPerf && cfgOk)
      cfgData <= cfgWord;
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      case (busAddr)
        ADDR_W'(OFS_PERF0):  busRdata = 32'(perfLvl[0]);
        ADDR_W'(OFS_PERF1):  busRdata = 32'(perfLvl[1]);
        ADDR_W'(OFS_STATUS): busRdata = 32'(status);
        ADDR_W'(OFS_RDATA):  busRdata = cfgData;
        default:             busRdata = '0;
      endcase
    end
  end

  assign irq = |status;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !opStrobe.finish) |=> !irq);  // R10
  AST_FINISH_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe.finish |=> irq);  // R11
  AST_CFG_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rstN)
    !(opStrobe.finish && !isPerf && cfgOk) |=> $stable(cfgData));  // R7

endmodule

// File: rtl/dvfs_req_engine.sv
module dvfs_req_engine
  import dvfs_req_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OP_CYCLES  = 150000,
  parameter int NUM_LEVELS = 8,
  parameter int CFG_WORDS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);

  opStrobe_t opStrobe;
  logic      busy;

  dvfs_req_ctrl #(
    .ADDR_W   (ADDR_W),
    .OP_CYCLES(OP_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .opStrobe(opStrobe),
    .busy    (busy)
  );

  dvfs_req_datapath #(
    .ADDR_W    (ADDR_W),
    .NUM_LEVELS(NUM_LEVELS),
    .CFG_WORDS (CFG_WORDS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .opStrobe(opStrobe),
    .busRdata(busRdata),
    .irq     (irq)
  );

endmodule

// File: tb/dvfs_req_engine_bench.sv
module dvfs_req_engine_bench;

  localparam int OPC = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dvfs_req_engine #(.OP_CYCLES(OPC)) u_dvfs_req_engine (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // {write offset, write data, expected status, readback offset, expected readback}
  localparam int NV = 10;
  localparam logic [91:0] VEC [NV] = '{
    {8'h00, 32'h0000_0003, 12'h001, 8'h00, 32'h0000_0003},  // R2 R5
    {8'h08, 32'h0000_0005, 12'h010, 8'h08, 32'h0000_0005},  // R2 R5
    {8'h08, 32'h0000_0009, 12'h020, 8'h08, 32'h0000_0005},  // R4
    {8'h10, 32'h8060_0004, 12'h100, 8'h74, 32'hC504_000D},  // R6
    {8'h10, 32'h8060_000F, 12'h100, 8'h74, 32'hC50F_002E},  // R6 last word
    {8'h10, 32'h8060_0010, 12'h200, 8'h74, 32'hC50F_002E},  // R7 offset out
    {8'h10, 32'h8050_0002, 12'h200, 8'h74, 32'hC50F_002E},  // R7 func
    {8'h00, 32'h0000_0007, 12'h001, 8'h00, 32'h0000_0007},  // R2 top level
    {8'h00, 32'h0000_0008, 12'h002, 8'h00, 32'h0000_0007},  // R4 R5
    {8'h10, 32'h0060_0003, 12'h000, 8'h74, 32'hC50F_002E}   // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitOp();
    repeat (OPC + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    busRd(8'h18, rd); check("R1 status", rd, 32'h0);
    busRd(8'h00, rd); check("R1 perf0", rd, 32'h0);
    busRd(8'h08, rd); check("R1 perf1", rd, 32'h0);
    busRd(8'h74, rd); check("R1 rdata", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      busWr(VEC[i][91:84], VEC[i][83:52]);
      waitOp();
      check("R11 irq level", 32'(irq), 32'(VEC[i][51:40] != 12'h0));
      busRd(8'h18, rd); check("R2/R4/R6/R7/R8 status", rd, 32'(VEC[i][51:40]));
      check("R10 irq after read", 32'(irq), 32'h0);
      busRd(VEC[i][39:32], rd); check("R5/R6 readback", rd, VEC[i][31:0]);
    end

    // R3 exact latency, observed on the pin only
    busWr(8'h08, 32'h2);
    repeat (OPC - 1) @(negedge clk);
    check("R3 not yet", 32'(irq), 32'h0);
    @(negedge clk);
    check("R3 on time", 32'(irq), 32'h1);
    busRd(8'h18, rd); check("R3 status", rd, 32'h010);
    busRd(8'h18, rd); check("R10 second read", rd, 32'h0);

    // R9 requests while busy
    busWr(8'h00, 32'h4);
    busWr(8'h08, 32'h6);
    busWr(8'h10, 32'h8060_0001);
    waitOp();
    busRd(8'h18, rd); check("R9 status", rd, 32'h001);
    busRd(8'h08, rd); check("R9 perf1 untouched", rd, 32'h2);
    busRd(8'h00, rd); check("R9 perf0 set", rd, 32'h4);
    busRd(8'h74, rd); check("R9 rdata untouched", rd, 32'hC50F_002E);

    // R11 accumulation of two results without a read in between
    busWr(8'h00, 32'h1);
    waitOp();
    busWr(8'h10, 32'h8060_0000);
    waitOp();
    check("R11 irq held", 32'(irq), 32'h1);
    busRd(8'h18, rd); check("R11 both bits", rd, 32'h101);
    busRd(8'h74, rd); check("R6 word zero", rd, 32'hC500_0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule